// File: doc/BRIEF.md
# Drive and Head Select Remapper

This block sits between a disk controller and a pair of physical drives. The controller has four drive-select outputs but only three head-select lines, while the system has only two drives. The block reuses the upper two controller selects. A request for head 8 or above is steered to controller select `unit + 2`. That select is then folded back onto the same physical drive and also drives a fourth head-select bit. With this scheme a drive with up to 16 heads can be addressed through a controller that only knows about 8.

A command begins with a one-cycle `cmd_go` strobe that carries a 2-bit unit number and a 4-bit head number. The remapped selection is captured in registers on that edge. It stays fixed until the next `cmd_go` or until `cmd_done` ends the command. While no command is active, every select is low. A unit number that names a drive that does not exist is flagged, and no drive is selected.

Top module: `dhs_remap`

## Requirements
- R1: During and directly after synchronous reset, `drv_sel`, `head_sel`, `ctl_dsel` and `unit_bad` are all zero.
- R2: A `cmd_go` with unit 0 or 1 and head 0..7 gives, from the next cycle on, `ctl_dsel` with only bit `unit` set, `drv_sel` with only bit `unit` set, and `head_sel` equal to the head number (bit 3 low).
- R3: A `cmd_go` with unit 0 or 1 and head 8..15 gives, from the next cycle on, `ctl_dsel` with only bit `unit+2` set, `drv_sel` with only bit `unit` set, and `head_sel` equal to the full 4-bit head number.
- R4: At all times `drv_sel[0]` is `ctl_dsel[0] | ctl_dsel[2]`, `drv_sel[1]` is `ctl_dsel[1] | ctl_dsel[3]`, and `head_sel[3]` is `ctl_dsel[2] | ctl_dsel[3]`.
- R5: A `cmd_go` with unit 2 or 3 sets `unit_bad` from the next cycle on and leaves `drv_sel`, `ctl_dsel` and `head_sel` all zero.
- R6: In cycles without `cmd_go` or `cmd_done`, all outputs hold their values, whatever the unit and head inputs do.
- R7: A `cmd_done` without `cmd_go` clears all outputs on the next cycle.
- R8: When `cmd_go` and `cmd_done` are high in the same cycle, the new command is captured and the clear is ignored.
- R9: At most one bit of `drv_sel` and at most one bit of `ctl_dsel` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | One-cycle strobe that starts a command |
| cmd_done | input | 1 | One-cycle strobe that ends the current command |
| unit_req | input | 2 | Requested drive unit number |
| head_req | input | 4 | Requested head number |
| drv_sel | output | 2 | One-hot physical drive selects |
| head_sel | output | 4 | Head select presented to the drives |
| ctl_dsel | output | 4 | Controller-side drive select after remapping |
| unit_bad | output | 1 | Captured request named a nonexistent unit |

## Verification
The hardest situation to reach is a held selection that must ignore new input values. It only shows up when `unit_req` and `head_req` change between strobes, including to invalid units and far heads, and the outputs stay put. The stimulus drives this case on purpose: it captures a far-head command, then sweeps the inputs for several cycles with both strobes low. The same directed sequence also issues `cmd_go` and `cmd_done` in the same cycle, which exercises the priority between the two strobes. That case never comes up in the table-driven part of the stimulus.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
    localparam int NUM_DRV    = 2;
    localparam int NUM_CSEL   = 2 * NUM_DRV;
    localparam int UNIT_W     = $clog2(NUM_CSEL);
    localparam int HEAD_W     = 4;
    localparam int CTL_HEAD_W = HEAD_W - 1;

    typedef struct packed {
        logic [NUM_CSEL-1:0]   dsel;
        logic [CTL_HEAD_W-1:0] head;
        logic                  bad;
    } ctl_req_t;

    function automatic logic unit_ok(input logic [UNIT_W-1:0] u);
        return int'(u) < NUM_DRV;
    endfunction

    function automatic logic head_far(input logic [HEAD_W-1:0] h);
        return h[HEAD_W-1];
    endfunction
endpackage

// File: rtl/dhs_unit_adjust.sv
module dhs_unit_adjust
    import dhs_pkg::*;
(
    input  logic [UNIT_W-1:0] unit_in,
    input  logic [HEAD_W-1:0] head_in,
    output ctl_req_t          req_out
);
    logic [UNIT_W-1:0] ctl_unit;

    always_comb begin
        ctl_unit = unit_in + (head_far(head_in) ? UNIT_W'(NUM_DRV) : UNIT_W'(0));
        req_out  = '0;
        if (unit_ok(unit_in)) begin
            req_out.dsel = NUM_CSEL'(1) << ctl_unit;
            req_out.head = head_in[CTL_HEAD_W-1:0];
        end else begin
            req_out.bad  = 1'b1;
        end
    end
endmodule

// File: rtl/dhs_select_fold.sv
module dhs_select_fold
    import dhs_pkg::*;
(
    input  logic [NUM_CSEL-1:0]   dsel_in,
    input  logic [CTL_HEAD_W-1:0] head_in,
    output logic [NUM_DRV-1:0]    drv_out,
    output logic [HEAD_W-1:0]     head_out
);
    for (genvar i = 0; i < NUM_DRV; i++) begin : g_fold
        assign drv_out[i] = dsel_in[i] | dsel_in[i+NUM_DRV];
    end

    assign head_out = {|dsel_in[NUM_CSEL-1:NUM_DRV], head_in};
endmodule

// File: rtl/dhs_remap.sv
module dhs_remap
    import dhs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_go,
    input  logic                cmd_done,
    input  logic [UNIT_W-1:0]   unit_req,
    input  logic [HEAD_W-1:0]   head_req,
    output logic [NUM_DRV-1:0]  drv_sel,
    output logic [HEAD_W-1:0]   head_sel,
    output logic [NUM_CSEL-1:0] ctl_dsel,
    output logic                unit_bad
);
    ctl_req_t req_next;
    ctl_req_t req_q;

    dhs_unit_adjust i_adjust (
        .unit_in (unit_req),
        .head_in (head_req),
        .req_out (req_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (cmd_go)
            req_q <= req_next;
        else if (cmd_done)
            req_q <= '0;
    end

    dhs_select_fold i_fold (
        .dsel_in  (req_q.dsel),
        .head_in  (req_q.head),
        .drv_out  (drv_sel),
        .head_out (head_sel)
    );

    assign ctl_dsel = req_q.dsel;
    assign unit_bad = req_q.bad;
endmodule

// File: rtl/dhs_remap_chk.sv
module dhs_remap_chk
    import dhs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cmd_go,
    input logic                cmd_done,
    input logic [UNIT_W-1:0]   unit_req,
    input logic [HEAD_W-1:0]   head_req,
    input logic [NUM_DRV-1:0]  drv_sel,
    input logic [HEAD_W-1:0]   head_sel,
    input logic [NUM_CSEL-1:0] ctl_dsel,
    input logic                unit_bad
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (drv_sel == '0 && ctl_dsel == '0 && !unit_bad));

    p_near_head_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && unit_ok(unit_req) && !head_far(head_req))
        |=> (!head_sel[HEAD_W-1] && ctl_dsel[NUM_CSEL-1:NUM_DRV] == '0 && drv_sel != '0));

    p_far_head_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && unit_ok(unit_req) && head_far(head_req))
        |=> (head_sel[HEAD_W-1] && ctl_dsel[NUM_DRV-1:0] == '0 && drv_sel != '0));

    p_head3_fold_r4: assert property (@(posedge clk) disable iff (rst)
        head_sel[HEAD_W-1] == (|ctl_dsel[NUM_CSEL-1:NUM_DRV]));

    p_bad_unit_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !unit_ok(unit_req))
        |=> (unit_bad && drv_sel == '0 && ctl_dsel == '0 && head_sel == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cmd_go && !cmd_done)
        |=> ($stable(drv_sel) && $stable(head_sel) && $stable(unit_bad)));

    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && !cmd_go) |=> (drv_sel == '0 && ctl_dsel == '0 && !unit_bad));

    p_go_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && cmd_done && unit_ok(unit_req)) |=> (drv_sel != '0));

    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(drv_sel) && $onehot0(ctl_dsel)));
endmodule

bind dhs_remap dhs_remap_chk i_dhs_remap_chk (.*);

// File: tb/test_dhs_remap.sv
module test_dhs_remap;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_go;
    logic       cmd_done;
    logic [1:0] unit_req;
    logic [3:0] head_req;
    logic [1:0] drv_sel;
    logic [3:0] head_sel;
    logic [3:0] ctl_dsel;
    logic       unit_bad;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dhs_remap i_dhs_remap (
        .clk, .rst, .cmd_go, .cmd_done, .unit_req, .head_req,
        .drv_sel, .head_sel, .ctl_dsel, .unit_bad
    );

    // {unit, head, drv_sel, head_sel, ctl_dsel, unit_bad}
    localparam logic [16:0] VEC [0:11] = '{
        {2'd0, 4'd0,  2'b01, 4'd0,  4'b0001, 1'b0},
        {2'd1, 4'd5,  2'b10, 4'd5,  4'b0010, 1'b0},
        {2'd0, 4'd7,  2'b01, 4'd7,  4'b0001, 1'b0},
        {2'd0, 4'd8,  2'b01, 4'd8,  4'b0100, 1'b0},
        {2'd1, 4'd8,  2'b10, 4'd8,  4'b1000, 1'b0},
        {2'd0, 4'd15, 2'b01, 4'd15, 4'b0100, 1'b0},
        {2'd1, 4'd12, 2'b10, 4'd12, 4'b1000, 1'b0},
        {2'd1, 4'd3,  2'b10, 4'd3,  4'b0010, 1'b0},
        {2'd2, 4'd4,  2'b00, 4'd0,  4'b0000, 1'b1},
        {2'd3, 4'd9,  2'b00, 4'd0,  4'b0000, 1'b1},
        {2'd1, 4'd9,  2'b10, 4'd9,  4'b1000, 1'b0},
        {2'd0, 4'd1,  2'b01, 4'd1,  4'b0001, 1'b0}
    };

    task automatic check_out(input string req, input logic [1:0] e_drv,
                             input logic [3:0] e_head, input logic [3:0] e_ctl,
                             input logic e_bad);
        checks++;
        if (drv_sel !== e_drv || head_sel !== e_head || ctl_dsel !== e_ctl || unit_bad !== e_bad) begin
            fails++;
            $display("FAIL %s: got drv=%b head=%h ctl=%b bad=%b, expected drv=%b head=%h ctl=%b bad=%b",
                     req, drv_sel, head_sel, ctl_dsel, unit_bad, e_drv, e_head, e_ctl, e_bad);
        end
    endtask

    task automatic issue(input logic [1:0] u, input logic [3:0] h, input logic done);
        @(negedge clk);
        unit_req = u; head_req = h; cmd_go = 1'b1; cmd_done = done;
        @(negedge clk);
        cmd_go = 1'b0; cmd_done = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_go = 1'b0; cmd_done = 1'b0; unit_req = '0; head_req = '0;
        repeat (3) @(negedge clk);
        check_out("R1 reset", 2'b00, 4'h0, 4'b0000, 1'b0);
        rst = 1'b0;

        // table walk: R2 near heads, R3 far heads, R5 bad units; R4 fold checked too
        for (int i = 0; i < 12; i++) begin
            logic [16:0] v;
            string tag;
            v = VEC[i];
            tag = v[0] ? "R5 bad unit" : (v[14] ? "R3 far head" : "R2 near head");
            issue(v[16:15], v[14:11], 1'b0);
            check_out(tag, v[10:9], v[8:5], v[4:1], v[0]);
            checks++;
            if (drv_sel[0] !== (ctl_dsel[0] | ctl_dsel[2]) || drv_sel[1] !== (ctl_dsel[1] | ctl_dsel[3])
                || head_sel[3] !== (ctl_dsel[2] | ctl_dsel[3]) || !$onehot0(drv_sel)) begin
                fails++;
                $display("FAIL R4/R9 fold: got drv=%b head=%h ctl=%b, expected folded consistent selects",
                         drv_sel, head_sel, ctl_dsel);
            end
        end

        // R6: capture far head, then sweep inputs without strobes
        issue(2'd1, 4'd13, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            unit_req = 2'(k); head_req = 4'(k * 5);
        end
        @(negedge clk);
        check_out("R6 hold", 2'b10, 4'd13, 4'b1000, 1'b0);

        // R7: done clears
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        check_out("R7 done clears", 2'b00, 4'h0, 4'b0000, 1'b0);

        // R7 after bad unit clears flag too
        issue(2'd3, 4'd2, 1'b0);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        check_out("R7 done clears bad", 2'b00, 4'h0, 4'b0000, 1'b0);

        // R8: go and done together, go wins
        issue(2'd0, 4'd10, 1'b1);
        check_out("R8 go wins", 2'b01, 4'd10, 4'b0100, 1'b0);

        // R1: reset mid-command
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_out("R1 reset mid-command", 2'b00, 4'h0, 4'b0000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule